// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Control

This block is a 16-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software gives each pin a mode (digital input, driven output, alternate function or analog) and a 2-bit drive-speed grade. The port holds the output data and captures pin levels into an input data register. Two write-only registers let software flip individual output bits without a read-modify-write: one sets and clears bits, the other only clears them. A keyed lock sequence can freeze the mode and speed of selected pins until the next reset.

In alternate-function mode a pin takes its level and its drive enable from a peripheral instead of the output data register. The sampled input levels also go back to on-chip peripherals. Every bus access gets a registered response one cycle later. Any access narrower than a full word is refused.

Register word offsets (byte addresses): 0x00 pin mode, 0x04 speed, 0x08 input data (read-only), 0x0C output data, 0x10 set/clear (write-only, reads 0), 0x14 clear-only (write-only, reads 0), 0x18 lock. Unmapped offsets read 0 and ignore writes.

Top module: `gpio_bank`

## Requirements
- R1: An access with `bus_size` other than 2'b10 (word), or with `bus_addr[1:0]` not zero, is refused. It gives `bus_err`=1 and `bus_rdata`=0 in the response cycle and changes no register.
- R2: A write to offset 0x10 sets output bit i when data bit i (0..15) is 1, and clears it when data bit 16+i is 1. If both are 1, the set wins. Bits written as 0 in both halves keep their value.
- R3: A write to offset 0x14 clears each output bit whose data bit (15:0) is 1. Bits 31:16 of that write, and bits written as 0, have no effect.
- R4: Outside analog mode, the level on each `pin_in` bit is captured into the input data register (offset 0x08) on every clock. A read returns the level present one clock before the read request.
- R5: The mode register at offset 0x00 holds field [2i+1:2i] for pin i: 00 input, 01 output, 10 alternate function, 11 analog. In output mode the pin drives `pin_out[i]` from the output data register with `pin_oe[i]`=1.
- R6: The speed register at offset 0x04 holds a 2-bit grade per pin in field [2i+1:2i] (00 low, 01 medium, 10 high, 11 very high). It reads back as written and appears on `pin_speed`.
- R7: For a locked pin, the mode and speed fields never change. A write to offset 0x00 or 0x04 while any pin is locked updates only the unlocked pins and answers with `bus_err`=1.
- R8: A pin in input or analog mode has `pin_oe`=0 (high impedance).
- R9: The lock register (offset 0x18) has its key at bit 16 and the pin mask at bits 15:0. The sequence is: write key=1, write key=0, write key=1 (all with the same mask), then one read. It locks the masked pins, and later reads return key=1 with the locked mask. Any other access to 0x18 during the sequence aborts it. Once the key is set, the lock register ignores everything until reset.
- R10: In alternate-function mode, `pin_out[i]` follows `af_out[i]` and `pin_oe[i]` follows `af_oe[i]`.
- R11: A pin in analog mode reads 0 in the input data register and on `periph_in`.
- R12: Every access with `bus_sel`=1 gives `bus_rvalid`=1 exactly one clock later, and a write returns read data 0. After reset, every register reads 0 and every pin has `pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 00 byte, 01 half-word, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response strobe, one cycle after request |
| bus_rdata | output | 32 | Read data of the response |
| bus_err | output | 1 | Error response |
| pin_in | input | NPINS | Pad input levels |
| af_out | input | NPINS | Peripheral output values for alternate-function pins |
| af_oe | input | NPINS | Peripheral drive enables for alternate-function pins |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad drive enables |
| pin_speed | output | 2*NPINS | Speed grade per pin |
| periph_in | output | NPINS | Sampled input levels for on-chip peripherals |

## Verification
Some properties are checked on every clock. These are the one-cycle response timing, error and zero data for narrow accesses, and untouched registers after a refusal. They also cover the set/clear and clear-only effects on the output register, freezing of locked mode and speed fields, and high impedance on input and analog pins. Input capture one clock after the pad level, the analog zero, and the fact that lock bits only grow are checked the same way. Other behaviours need the bench's ordered scenarios: a lock sequence that aborts and then succeeds, a frozen lock register after success, and the readback of a locked configuration after a refused write. The bench also checks alternate-function pass-through and the register readback values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  // word index of each register (byte address bits 4:2)
  localparam logic [2:0] RI_MODE   = 3'd0;
  localparam logic [2:0] RI_SPEED  = 3'd1;
  localparam logic [2:0] RI_IDATA  = 3'd2;
  localparam logic [2:0] RI_ODATA  = 3'd3;
  localparam logic [2:0] RI_SETCLR = 3'd4;
  localparam logic [2:0] RI_CLR    = 3'd5;
  localparam logic [2:0] RI_LOCK   = 3'd6;

  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam int         KEY_BIT  = 16;
  localparam int         CLR_BASE = 16;

endpackage

// File: rtl/gpio_bank_lock.sv
module gpio_bank_lock
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_wr,
  input  logic             lk_rd,
  input  logic             lk_key,
  input  logic [NPINS-1:0] lk_mask,
  output logic [NPINS-1:0] locked_q,
  output logic             key_q
);

  typedef enum logic [1:0] {LS_IDLE, LS_ONE, LS_ZERO, LS_ARMED} lk_state_e;

  lk_state_e        st_q;
  logic [NPINS-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= LS_IDLE;
      pend_q   <= '0;
      locked_q <= '0;
      key_q    <= 1'b0;
    end else if (!key_q) begin
      unique case (st_q)
        LS_IDLE: begin
          if (lk_wr && lk_key) begin
            st_q   <= LS_ONE;
            pend_q <= lk_mask;
          end
        end
        LS_ONE: begin
          if (lk_wr && !lk_key && lk_mask == pend_q) st_q <= LS_ZERO;
          else if (lk_wr || lk_rd)                   st_q <= LS_IDLE;
        end
        LS_ZERO: begin
          if (lk_wr && lk_key && lk_mask == pend_q) st_q <= LS_ARMED;
          else if (lk_wr || lk_rd)                  st_q <= LS_IDLE;
        end
        LS_ARMED: begin
          if (lk_rd) begin
            locked_q <= pend_q;
            key_q    <= 1'b1;
            st_q     <= LS_IDLE;
          end else if (lk_wr) begin
            st_q <= LS_IDLE;
          end
        end
        default: st_q <= LS_IDLE;
      endcase
    end
  end

  // R9: lock bits never drop once set
  a_r9_mask_grows: assert property (@(posedge clk) disable iff (rst)
    (($past(locked_q) & ~locked_q) == '0));
  // R9: key stays set until reset
  a_r9_key_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(key_q) |-> key_q);
  // R9: key only rises on the closing read of an armed sequence
  a_r9_key_by_read: assert property (@(posedge clk) disable iff (rst)
    $rose(key_q) |-> ($past(st_q) == LS_ARMED && $past(lk_rd)));

endmodule

// File: rtl/gpio_bank_odata.sv
module gpio_bank_odata
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_full,
  input  logic             wr_setclr,
  input  logic             wr_clr,
  input  logic [31:0]      wdata,
  output logic [NPINS-1:0] odata_q
);

  logic [NPINS-1:0] set_bits, clr_bits, clr_only;

  assign set_bits = wdata[NPINS-1:0];
  assign clr_bits = wdata[CLR_BASE +: NPINS];
  assign clr_only = wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst)            odata_q <= '0;
    else if (wr_full)   odata_q <= wdata[NPINS-1:0];
    else if (wr_setclr) odata_q <= (odata_q & ~clr_bits) | set_bits;
    else if (wr_clr)    odata_q <= odata_q & ~clr_only;
  end

  // R2: every bit asked to be set is 1 afterwards (set beats clear)
  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> ((odata_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));
  // R2: bits zero in both halves are untouched
  a_r2_rest_kept: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> (((odata_q ^ $past(odata_q)) &
                    ~($past(wdata[NPINS-1:0]) | $past(wdata[CLR_BASE +: NPINS]))) == '0));
  // R3: clear-only write zeroes selected bits and touches nothing else
  a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((odata_q == ($past(odata_q) & ~$past(wdata[NPINS-1:0])))));

endmodule

// File: rtl/gpio_bank_pinmux.sv
module gpio_bank_pinmux
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic [2*NPINS-1:0] mode_q,
  input  logic [NPINS-1:0]   odata_q,
  input  logic [NPINS-1:0]   af_out,
  input  logic [NPINS-1:0]   af_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   ana_mask
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_comb begin
      pin_out[g]  = 1'b0;
      pin_oe[g]   = 1'b0;
      ana_mask[g] = 1'b0;
      case (mode_q[2*g +: 2])
        PM_OUT: begin
          pin_out[g] = odata_q[g];
          pin_oe[g]  = 1'b1;
        end
        PM_ALT: begin
          pin_out[g] = af_out[g];
          pin_oe[g]  = af_oe[g];
        end
        PM_ANA:  ana_mask[g] = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic                bus_rvalid,
  output logic [31:0]         bus_rdata,
  output logic                bus_err,
  input  logic [NPINS-1:0]    pin_in,
  input  logic [NPINS-1:0]    af_out,
  input  logic [NPINS-1:0]    af_oe,
  output logic [NPINS-1:0]    pin_out,
  output logic [NPINS-1:0]    pin_oe,
  output logic [2*NPINS-1:0]  pin_speed,
  output logic [NPINS-1:0]    periph_in
);

  // NPINS must not exceed 16: the set/clear word splits at bit 16
  localparam int W2 = 2 * NPINS;

  logic [W2-1:0]    mode_q, speed_q, lk_exp;
  logic [NPINS-1:0] idata_q, odata_q, locked_q, ana_mask, hiz_mask;
  logic             key_q;
  logic             word_ok, region_ok, acc, cfg_err;
  logic [2:0]       idx;
  logic             wr_mode, wr_speed, wr_odata, wr_setclr, wr_clr, wr_lock, rd_lock;
  logic [31:0]      rd_mux;

  // ---------------- decode ----------------
  assign word_ok   = (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
  assign region_ok = (bus_addr >> 5) == '0;
  assign idx       = bus_addr[4:2];
  assign acc       = bus_sel && word_ok && region_ok;

  assign wr_mode   = acc && bus_wr  && idx == RI_MODE;
  assign wr_speed  = acc && bus_wr  && idx == RI_SPEED;
  assign wr_odata  = acc && bus_wr  && idx == RI_ODATA;
  assign wr_setclr = acc && bus_wr  && idx == RI_SETCLR;
  assign wr_clr    = acc && bus_wr  && idx == RI_CLR;
  assign wr_lock   = acc && bus_wr  && idx == RI_LOCK;
  assign rd_lock   = acc && !bus_wr && idx == RI_LOCK;
  assign cfg_err   = (wr_mode || wr_speed) && (|locked_q);

  for (genvar g = 0; g < NPINS; g++) begin : g_exp
    assign lk_exp[2*g +: 2] = {2{locked_q[g]}};
    assign hiz_mask[g] = (mode_q[2*g +: 2] == PM_IN) || (mode_q[2*g +: 2] == PM_ANA);
  end

  // ---------------- configuration and input capture ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      speed_q <= '0;
      idata_q <= '0;
    end else begin
      idata_q <= pin_in & ~ana_mask;
      if (wr_mode)  mode_q  <= (mode_q  & lk_exp) | (bus_wdata[W2-1:0] & ~lk_exp);
      if (wr_speed) speed_q <= (speed_q & lk_exp) | (bus_wdata[W2-1:0] & ~lk_exp);
    end
  end

  gpio_bank_odata #(.NPINS(NPINS)) u_odata (
    .clk      (clk),
    .rst      (rst),
    .wr_full  (wr_odata),
    .wr_setclr(wr_setclr),
    .wr_clr   (wr_clr),
    .wdata    (bus_wdata),
    .odata_q  (odata_q)
  );

  gpio_bank_lock #(.NPINS(NPINS)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .lk_wr   (wr_lock),
    .lk_rd   (rd_lock),
    .lk_key  (bus_wdata[KEY_BIT]),
    .lk_mask (bus_wdata[NPINS-1:0]),
    .locked_q(locked_q),
    .key_q   (key_q)
  );

  gpio_bank_pinmux #(.NPINS(NPINS)) u_pinmux (
    .mode_q  (mode_q),
    .odata_q (odata_q),
    .af_out  (af_out),
    .af_oe   (af_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .ana_mask(ana_mask)
  );

  // ---------------- read path and response ----------------
  always_comb begin
    rd_mux = '0;
    case (idx)
      RI_MODE:  rd_mux[W2-1:0]    = mode_q;
      RI_SPEED: rd_mux[W2-1:0]    = speed_q;
      RI_IDATA: rd_mux[NPINS-1:0] = idata_q;
      RI_ODATA: rd_mux[NPINS-1:0] = odata_q;
      RI_LOCK: begin
        rd_mux[KEY_BIT]    = key_q;
        rd_mux[NPINS-1:0]  = locked_q;
      end
      default: ;
    endcase
    if (!region_ok) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel;
      bus_err    <= bus_sel && (!word_ok || cfg_err);
      bus_rdata  <= (acc && !bus_wr) ? rd_mux : '0;
    end
  end

  assign pin_speed = speed_q;
  assign periph_in = idata_q;

  // ---------------- assertions ----------------
  // R12: one response per request, one cycle later
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    bus_sel |=> bus_rvalid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (!bus_rvalid && !bus_err));
  // R1: narrow access answers with error and zero data
  a_r1_narrow_err: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_size != SZ_WORD) |=> (bus_err && bus_rdata == '0));
  // R1: refused access changes no register
  a_r1_narrow_inert: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !word_ok) |=> ($stable(mode_q) && $stable(speed_q) && $stable(odata_q)
                               && $stable(locked_q)));
  // R7: locked fields hold while the lock mask is unchanged
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    $stable(lk_exp) |-> ((mode_q & lk_exp) == ($past(mode_q) & lk_exp)));
  a_r7_speed_frozen: assert property (@(posedge clk) disable iff (rst)
    $stable(lk_exp) |-> ((speed_q & lk_exp) == ($past(speed_q) & lk_exp)));
  // R8: input and analog pins never drive
  a_r8_hiz: assert property (@(posedge clk) disable iff (rst)
    ((hiz_mask & pin_oe) == '0));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    // R4: digital pins capture the pad level one clock later
    a_r4_sampled: assert property (@(posedge clk) disable iff (rst)
      !ana_mask[g] |=> (idata_q[g] == $past(pin_in[g])));
    // R11: analog pins read 0
    a_r11_ana_zero: assert property (@(posedge clk) disable iff (rst)
      ana_mask[g] |=> !idata_q[g]);
  end

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  localparam int NP = 16;

  localparam logic [4:0] A_MODE = 5'h00, A_SPEED = 5'h04, A_IDATA = 5'h08,
                         A_ODATA = 5'h0C, A_SETCLR = 5'h10, A_CLR = 5'h14, A_LOCK = 5'h18;
  localparam logic [1:0] SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10;

  logic            clk = 1'b0;
  logic            rst;
  logic            bus_sel, bus_wr;
  logic [4:0]      bus_addr;
  logic [1:0]      bus_size;
  logic [31:0]     bus_wdata;
  logic            bus_rvalid, bus_err;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pin_in, af_out, af_oe, pin_out, pin_oe, periph_in;
  logic [2*NP-1:0] pin_speed;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] r_data;
  logic        r_err, r_valid;

  always #5 clk = ~clk;

  gpio_bank #(.NPINS(NP), .ADDR_W(5)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in), .af_out(af_out),
    .af_oe(af_oe), .pin_out(pin_out), .pin_oe(pin_oe), .pin_speed(pin_speed),
    .periph_in(periph_in)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h00, 32'h5555_5555, 32'h0},          // R5 all outputs
    '{1'b1, 5'h0C, 32'h0000_00F0, 32'h0},
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00F0},
    '{1'b1, 5'h10, 32'h0010_0001, 32'h0},          // R2 set 0, clear 4
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00E1},
    '{1'b1, 5'h10, 32'h0001_0001, 32'h0},          // R2 set wins
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00E1},
    '{1'b1, 5'h14, 32'h0000_0021, 32'h0},          // R3 clear 0 and 5
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00C0},
    '{1'b1, 5'h14, 32'hFFFF_0000, 32'h0},          // R3 upper half ignored
    '{1'b0, 5'h0C, 32'h0,         32'h0000_00C0},
    '{1'b1, 5'h04, 32'hA5A5_0F0F, 32'h0},          // R6
    '{1'b0, 5'h04, 32'h0,         32'hA5A5_0F0F},
    '{1'b0, 5'h00, 32'h0,         32'h5555_5555},
    '{1'b0, 5'h10, 32'h0,         32'h0}           // R2 write-only reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with the response
  task automatic acc(input logic wr, input logic [4:0] a, input logic [1:0] sz,
                     input logic [31:0] wd);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    r_data = bus_rdata; r_err = bus_err; r_valid = bus_rvalid;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = SZ_W;
    bus_wdata = '0; pin_in = '0; af_out = '0; af_oe = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    chk("R12 oe after reset", {16'b0, pin_oe}, 32'h0);
    acc(1'b0, A_MODE, SZ_W, 0);
    chk("R12 mode reset", r_data, 32'h0);
    chk("R12 rvalid strobe", {31'b0, r_valid}, 32'h1);
    acc(1'b0, A_LOCK, SZ_W, 0);
    chk("R12 lock reset", r_data, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].addr, SZ_W, VECS[i].wd);
      if (VECS[i].wr) chk("R2/R3/R5/R6 write no error", {31'b0, r_err}, 32'h0);
      else            chk("R2/R3/R5/R6 readback", r_data, VECS[i].exp);
    end

    // R5 output mode drives data
    chk("R5 pin_out", {16'b0, pin_out}, 32'h0000_00C0);
    chk("R5 pin_oe", {16'b0, pin_oe}, 32'h0000_FFFF);
    chk("R6 pin_speed", pin_speed, 32'hA5A5_0F0F);

    // R1 refused accesses
    acc(1'b1, A_ODATA, SZ_B, 32'h55);
    chk("R1 byte write err", {31'b0, r_err}, 32'h1);
    chk("R1 byte write rdata", r_data, 32'h0);
    acc(1'b0, A_ODATA, SZ_W, 0);
    chk("R1 odata untouched", r_data, 32'h0000_00C0);
    acc(1'b0, A_MODE, SZ_H, 0);
    chk("R1 half read err", {31'b0, r_err}, 32'h1);
    chk("R1 half read rdata", r_data, 32'h0);
    acc(1'b0, 5'h0D, SZ_W, 0);
    chk("R1 misaligned err", {31'b0, r_err}, 32'h1);

    // R4 input sampling, R8 high impedance
    acc(1'b1, A_MODE, SZ_W, 32'h0);
    pin_in = 16'hA5C3;
    @(negedge clk);
    chk("R8 input oe", {16'b0, pin_oe}, 32'h0);
    acc(1'b0, A_IDATA, SZ_W, 0);
    chk("R4 idata first", r_data, 32'h0000_A5C3);
    pin_in = 16'h5A3C;
    @(negedge clk);
    acc(1'b0, A_IDATA, SZ_W, 0);
    chk("R4 idata follows", r_data, 32'h0000_5A3C);

    // R11 analog pin 0
    acc(1'b1, A_MODE, SZ_W, 32'h3);
    pin_in = 16'hFFFF;
    @(negedge clk);
    acc(1'b0, A_IDATA, SZ_W, 0);
    chk("R11 analog idata", r_data, 32'h0000_FFFE);
    chk("R11 analog periph_in", {16'b0, periph_in}, 32'h0000_FFFE);
    chk("R8 analog oe", {16'b0, pin_oe}, 32'h0);

    // R10 alternate function
    acc(1'b1, A_MODE, SZ_W, 32'hAAAA_AAAA);
    af_out = 16'h1234; af_oe = 16'h00FF;
    @(negedge clk);
    chk("R10 af pin_out", {16'b0, pin_out}, 32'h0000_1234);
    chk("R10 af pin_oe", {16'b0, pin_oe}, 32'h0000_00FF);

    // R9 aborted sequence
    acc(1'b1, A_MODE, SZ_W, 32'h5555_5555);
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_0003);
    acc(1'b1, A_LOCK, SZ_W, 32'h0000_0004);
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_0003);
    acc(1'b0, A_LOCK, SZ_W, 0);
    acc(1'b0, A_LOCK, SZ_W, 0);
    chk("R9 aborted sequence", r_data, 32'h0);
    acc(1'b1, A_MODE, SZ_W, 32'h5555_5555);
    chk("R9 still unlocked", {31'b0, r_err}, 32'h0);

    // R9 good sequence
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_0003);
    acc(1'b1, A_LOCK, SZ_W, 32'h0000_0003);
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_0003);
    acc(1'b0, A_LOCK, SZ_W, 0);
    acc(1'b0, A_LOCK, SZ_W, 0);
    chk("R9 lock readback", r_data, 32'h0001_0003);

    // R7 locked configuration
    acc(1'b1, A_MODE, SZ_W, 32'h0);
    chk("R7 mode write err", {31'b0, r_err}, 32'h1);
    acc(1'b0, A_MODE, SZ_W, 0);
    chk("R7 mode locked fields", r_data, 32'h0000_0005);
    acc(1'b1, A_SPEED, SZ_W, 32'h0);
    chk("R7 speed write err", {31'b0, r_err}, 32'h1);
    acc(1'b0, A_SPEED, SZ_W, 0);
    chk("R7 speed locked fields", r_data, 32'h0000_000F);

    // R9 lock register frozen after success
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_00F0);
    acc(1'b1, A_LOCK, SZ_W, 32'h0000_00F0);
    acc(1'b1, A_LOCK, SZ_W, 32'h0001_00F0);
    acc(1'b0, A_LOCK, SZ_W, 0);
    acc(1'b0, A_LOCK, SZ_W, 0);
    chk("R9 lock frozen", r_data, 32'h0001_0003);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule